// File: doc/BRIEF.md
# Pipeline Hazard and Operand Forwarding Control

This block resolves the data and control hazards of a five-stage in-order pipeline. The stages are fetch, decode/operand read, ALU, memory access and register write, with pipeline registers between them. Each cycle it compares the source register numbers of the instruction in decode with the destination numbers of the older instructions in the ALU and memory stages. From that comparison it picks, for each decode operand, whether the value comes from the register file, from the ALU-stage result or from the memory-stage result. Forwarded values enter the decode-stage operand latch, not the ALU inputs.

A load still sitting in the ALU stage has no data yet. When decode reads its destination, the block raises a stall. The stall holds fetch and decode and sends a nop into the ALU stage. A taken branch resolved in the ALU stage raises a flush, which squashes the two younger instructions in fetch and decode so that they leave no architectural effect. The block is purely combinational and sits beside the pipeline registers, which act on its outputs.

An instruction in the register-write stage needs no action. The register file writes and reads in the same cycle.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: When the ALU-stage instruction has its write flag set, is not a load, and its destination equals a nonzero decode source, that operand's select is 1 (ALU result).
- R2: When a nonzero decode source equals the destination of a writing memory-stage instruction and the ALU stage does not also match it, that operand's select is 2 (memory result).
- R3: When both the ALU-stage and memory-stage destinations match the same source, the ALU stage wins, because it holds the younger producer.
- R4: A source register number of 0 never forwards and never stalls; its select is 0 (register file).
- R5: A stage whose write flag is clear takes no part in any comparison, whatever its destination and load flag are.
- R6: When a writing load in the ALU stage matches either nonzero decode source, stall is 1 and the select of each matching operand is 0.
- R7: A load in the memory stage is forwarded like any other result (select 2) and causes no stall.
- R8: The flush output follows the taken-branch input in the same cycle.
- R9: When flush and a load-use match occur together, flush is 1 and stall is 0.
- R10: With no match in either stage, both selects are 0 and stall is 0. The select value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_rs1 | input | REG_W | First source register of the decode-stage instruction |
| dec_rs2 | input | REG_W | Second source register of the decode-stage instruction |
| ex_rd | input | REG_W | Destination register of the ALU-stage instruction |
| ex_wen | input | 1 | ALU-stage instruction writes a register |
| ex_load | input | 1 | ALU-stage instruction is a load |
| mem_rd | input | REG_W | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| br_taken | input | 1 | Branch in the ALU stage resolved as taken |
| fwd_a | output | 2 | Operand 1 source: 0 register file, 1 ALU result, 2 memory result |
| fwd_b | output | 2 | Operand 2 source, same encoding |
| stall | output | 1 | Hold fetch and decode and inject a nop into the ALU stage |
| flush | output | 1 | Squash the instructions in fetch and decode |

## Verification
Every evaluation is checked against a set of invariants:
- register 0 never forwards;
- the select value 3 never appears;
- a stall always has a writing ALU-stage load behind it;
- a stall never coexists with a flush;
- a non-load match in the ALU stage always selects the ALU result.

Other behaviours only show up in the bench's scenarios. These are the exact select chosen when both stages match, the effect of clearing a write flag, and the treatment of a load that has already reached the memory stage. Random register numbers are drawn from a small range so that these collisions occur often.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_ALU = 2'd1,
    FWD_MEM = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
  import pipe_hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wen,
  output fwd_sel_e         sel,
  output logic             load_hit
);
  // A producer counts only if it writes a nonzero register equal to src
  function automatic logic producer_hit(input logic [REG_W-1:0] s,
                                        input logic [REG_W-1:0] rd,
                                        input logic             wen);
    return wen && (s != '0) && (rd == s);
  endfunction

  logic ex_hit, mem_hit;

  assign ex_hit   = producer_hit(src, ex_rd, ex_wen);
  assign mem_hit  = producer_hit(src, mem_rd, mem_wen);
  assign load_hit = ex_hit && ex_load;

  always_comb begin
    if (ex_hit) begin
      sel = ex_load ? FWD_RF : FWD_ALU;  // younger producer first
    end else if (mem_hit) begin
      sel = FWD_MEM;
    end else begin
      sel = FWD_RF;
    end
  end

  always_comb begin
    if (src == '0) begin
      AST_ZERO_NO_FWD: assert (sel == FWD_RF && !load_hit)
        else $error("register 0 forwarded");  // R4
    end
    if (ex_hit && !ex_load) begin
      AST_ALU_FIRST: assert (sel == FWD_ALU)
        else $error("ALU-stage match not selected");  // R3
    end
  end
endmodule

// File: rtl/hz_ctl.sv
module hz_ctl #(
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0] load_hit,
  input  logic            br_taken,
  output logic            stall,
  output logic            flush
);
  assign flush = br_taken;
  assign stall = (|load_hit) && !br_taken;

  always_comb begin
    AST_FLUSH_OVER_STALL: assert (!(stall && flush))
      else $error("stall during flush");  // R9
  end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
  import pipe_hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] dec_rs1,
  input  logic [REG_W-1:0] dec_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wen,
  input  logic             br_taken,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             stall,
  output logic             flush
);
  localparam int NSRC = 2;

  logic [REG_W-1:0] src_num [NSRC];
  fwd_sel_e         src_sel [NSRC];
  logic [NSRC-1:0]  load_hit;

  assign src_num[0] = dec_rs1;
  assign src_num[1] = dec_rs2;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    hz_src_match #(.REG_W(REG_W)) u_match (
      .src     (src_num[i]),
      .ex_rd   (ex_rd),
      .ex_wen  (ex_wen),
      .ex_load (ex_load),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .sel     (src_sel[i]),
      .load_hit(load_hit[i])
    );
  end

  hz_ctl #(.NSRC(NSRC)) u_ctl (
    .load_hit(load_hit),
    .br_taken(br_taken),
    .stall   (stall),
    .flush   (flush)
  );

  assign fwd_a = src_sel[0];
  assign fwd_b = src_sel[1];

  always_comb begin
    AST_SEL_LEGAL: assert (fwd_a != 2'd3 && fwd_b != 2'd3)
      else $error("illegal select");  // R10
    if (stall) begin
      AST_STALL_CAUSE: assert (ex_load && ex_wen)
        else $error("stall without ALU-stage load");  // R6
    end
  end
endmodule

// File: tb/pipe_hazard_ctl_test.sv
module pipe_hazard_ctl_test;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [RW-1:0] rs1, rs2, exrd, memrd;
  logic exw, exl, memw, br;
  logic [1:0] fa, fb;
  logic st, fl;
  int checks = 0;
  int errors = 0;

  pipe_hazard_ctl #(.REG_W(RW)) uut (
    .dec_rs1(rs1), .dec_rs2(rs2), .ex_rd(exrd), .ex_wen(exw), .ex_load(exl),
    .mem_rd(memrd), .mem_wen(memw), .br_taken(br),
    .fwd_a(fa), .fwd_b(fb), .stall(st), .flush(fl)
  );

  function automatic int want_sel(input logic [RW-1:0] s);
    if (s == 0) return 0;
    if (exw && exrd == s) return exl ? 0 : 1;
    if (memw && memrd == s) return 2;
    return 0;
  endfunction

  function automatic int want_stall();
    bit uses = exw && exl && exrd != 0 && (exrd == rs1 || exrd == rs2);
    return (uses && !br) ? 1 : 0;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input int er, input bit ew,
                       input bit el, input int mr, input bit mw, input bit bt,
                       input string req);
    @(negedge clk);
    rs1 = a[RW-1:0]; rs2 = b[RW-1:0]; exrd = er[RW-1:0]; exw = ew; exl = el;
    memrd = mr[RW-1:0]; memw = mw; br = bt;
    #1;
    check(req, int'(fa), want_sel(rs1));
    check(req, int'(fb), want_sel(rs2));
    check(req, int'(st), want_stall());
    check(req, int'(fl), int'(br));
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd17;
    void'($urandom(seed));
    rs1 = '0; rs2 = '0; exrd = '0; memrd = '0;
    exw = 0; exl = 0; memw = 0; br = 0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R10 idle state: nothing in flight
    apply(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    check("R10", int'(fa), 0);
    // R1 ALU forward to operand 1
    apply(3, 4, 3, 1, 0, 0, 0, 0, "R1");
    check("R1", int'(fa), 1);
    // R2 memory forward to operand 2
    apply(3, 4, 7, 1, 0, 4, 1, 0, "R2");
    check("R2", int'(fb), 2);
    // R3 both stages match
    apply(5, 5, 5, 1, 0, 5, 1, 0, "R3");
    check("R3", int'(fa), 1);
    // R4 register 0
    apply(0, 0, 0, 1, 1, 0, 1, 0, "R4");
    check("R4", int'(st), 0);
    // R5 write flags clear
    apply(6, 6, 6, 0, 1, 6, 0, 0, "R5");
    check("R5", int'(fa) + int'(st), 0);
    // R6 load-use on operand 2
    apply(1, 9, 9, 1, 1, 9, 1, 0, "R6");
    check("R6", int'(st), 1);
    check("R6", int'(fb), 0);
    // R7 load already in memory stage
    apply(8, 2, 3, 1, 0, 8, 1, 0, "R7");
    check("R7", int'(fa), 2);
    // R8 branch taken
    apply(1, 2, 0, 0, 0, 0, 0, 1, "R8");
    check("R8", int'(fl), 1);
    // R9 flush beats load-use
    apply(4, 4, 4, 1, 1, 0, 0, 1, "R9");
    check("R9", int'(st), 0);
    // random mix with small register range for collisions
    for (int i = 0; i < 3000; i++) begin
      apply(int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
            1'($urandom), 1'($urandom), int'($urandom % 4), 1'($urandom),
            ($urandom % 8) == 0, "R1 R2 R3 R6 R9 random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule